// File: doc/BRIEF.md
# PAUSE Receive Backoff Timer

This block sits beside a full-duplex Ethernet MAC transmitter and turns received PAUSE requests into a transmit hold. A frame parser elsewhere raises a one-cycle strobe with the 16-bit pause quantity from a PAUSE frame that has passed all checks. The timer then holds back new data frames for that many pause quanta. Each quantum is 512 bit times, which is 128 cycles of the 25 MHz nibble clock at 100 Mb/s.

A PAUSE that arrives while a frame is still going out is parked until the transmitter goes idle, so the frame in flight always finishes. If several arrive during one frame, only the newest is kept. A later PAUSE replaces the running count, and a quantity of zero ends the hold at once. MAC control frames are never held back. Clearing the enable turns the function off, opens the transmitter and discards any count or parked request.

Top module: `pause_backoff_timer`

## Requirements
- R1: After reset, `tx_allow` is 1 and no hold is running.
- R2: A strobe with quantity n > 0, sampled while `tx_busy` is 0, drives `tx_allow` to 0 for exactly n × PRESCALE cycles, starting in the cycle after the strobe edge. This assumes `next_is_ctrl` is 0 and the hold is not interrupted.
- R3: A strobe with quantity 0, sampled while `tx_busy` is 0, ends any hold: `tx_allow` is 1 in the next cycle.
- R4: A strobe with a nonzero quantity during a running hold restarts the count. The hold then lasts the new n × PRESCALE cycles from that strobe.
- R5: A strobe sampled while `tx_busy` is 1 does not start a hold. It is applied at the first edge where `tx_busy` is 0, and the hold runs for n × PRESCALE cycles from that edge.
- R6: When more than one strobe arrives during a single transmission, only the last one is applied once `tx_busy` falls.
- R7: While `next_is_ctrl` is 1, `tx_allow` is 1 even during a hold. The hold keeps counting and still ends at its original time.
- R8: While `fc_enable` is 0, `tx_allow` is 1 and strobes are ignored. A running count and any parked request are cleared, so after re-enabling no hold remains.
- R9: A zero-quantity strobe while no hold is running leaves `tx_allow` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz nibble clock |
| rst_n | input | 1 | asynchronous reset, active low |
| fc_enable | input | 1 | 1 enables PAUSE-driven flow control |
| pause_valid | input | 1 | one-cycle strobe for a valid received PAUSE |
| pause_time | input | QUANTA_W | requested pause in 512-bit-time quanta |
| tx_busy | input | 1 | 1 while the transmitter is sending a frame |
| next_is_ctrl | input | 1 | 1 when the next frame to send is a MAC control frame |
| tx_allow | output | 1 | 1 when the transmitter may start the next frame |

## Verification
The bench measures the exact length of the hold at both ends. A prescaler off by one, or a count that releases one quantum early or late, would show up as `tx_allow` rising one cycle away from n × 128. It raises strobes during a busy transmission to catch a design that starts the hold mid-frame, or one that keeps the first parked value instead of the last. It also checks that a zero quantity releases at once, that a new quantity restarts the count rather than adding to it or being ignored, and that the control-frame bypass leaves the count running. A design that failed to clear the count on disable would show a stale hold after re-enabling.

// File: rtl/pause_backoff_timer.sv
module pause_backoff_timer #(
  parameter int PRESCALE = 128,
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fc_enable,
  input  logic                pause_valid,
  input  logic [QUANTA_W-1:0] pause_time,
  input  logic                tx_busy,
  input  logic                next_is_ctrl,
  output logic                tx_allow
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [QUANTA_W-1:0] quanta_q;
  logic [QUANTA_W-1:0] pend_q;
  logic [PW-1:0]       presc_q;
  logic                pend_vld;

  wire hold      = quanta_q != '0;
  wire take_now  = pause_valid && !tx_busy;
  wire take_pend = pend_vld && !tx_busy && !pause_valid;
  wire [QUANTA_W-1:0] load_val = pause_valid ? pause_time : pend_q;
  wire quantum_end = hold && (presc_q == PLAST);

  assign tx_allow = !fc_enable || next_is_ctrl || !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quanta_q <= '0;
      presc_q  <= '0;
    end else if (!fc_enable) begin
      quanta_q <= '0;
      presc_q  <= '0;
    end else if (take_now || take_pend) begin
      quanta_q <= load_val;
      presc_q  <= '0;
    end else if (quantum_end) begin
      quanta_q <= quanta_q - 1'b1;
      presc_q  <= '0;
    end else if (hold) begin
      presc_q  <= presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_q   <= '0;
    end else if (!fc_enable) begin
      pend_vld <= 1'b0;
      pend_q   <= '0;
    end else if (pause_valid && tx_busy) begin
      pend_vld <= 1'b1;
      pend_q   <= pause_time;
    end else if (!tx_busy) begin
      pend_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/pause_backoff_timer_chk.sv
module pause_backoff_timer_chk #(
  parameter int QUANTA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fc_enable,
  input logic                pause_valid,
  input logic [QUANTA_W-1:0] pause_time,
  input logic                tx_busy,
  input logic                next_is_ctrl,
  input logic                tx_allow,
  input logic                hold,
  input logic                pend_vld
);
  assert_load_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fc_enable && pause_valid && !tx_busy && pause_time != '0
    |=> (!tx_allow || next_is_ctrl || !fc_enable));

  assert_zero_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fc_enable && pause_valid && !tx_busy && pause_time == '0 |=> tx_allow);

  assert_no_start_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !$past(tx_busy));

  assert_pend_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld && tx_busy && fc_enable |=> pend_vld);

  assert_ctrl_exempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold && next_is_ctrl |-> tx_allow);

  assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_enable |=> (!hold && !pend_vld && tx_allow));
endmodule

bind pause_backoff_timer pause_backoff_timer_chk #(.QUANTA_W(QUANTA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .pause_valid(pause_valid),
  .pause_time(pause_time), .tx_busy(tx_busy), .next_is_ctrl(next_is_ctrl),
  .tx_allow(tx_allow), .hold(hold), .pend_vld(pend_vld)
);

// File: tb/tb_pause_backoff_timer.sv
`timescale 1ns/1ps
module tb_pause_backoff_timer;
  localparam int P = 128;
  logic clk = 1'b0, rst_n = 1'b0, fc_enable = 1'b1, pause_valid = 1'b0;
  logic tx_busy = 1'b0, next_is_ctrl = 1'b0;
  logic [15:0] pause_time = '0;
  logic tx_allow;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pause_backoff_timer #(.PRESCALE(P), .QUANTA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .pause_valid(pause_valid),
    .pause_time(pause_time), .tx_busy(tx_busy), .next_is_ctrl(next_is_ctrl),
    .tx_allow(tx_allow));

  task automatic chk(input logic exp, input string req);
    #1;
    total++;
    if (tx_allow !== exp) begin
      bad++;
      $display("FAIL %s: tx_allow=%b expected=%b at %0t", req, tx_allow, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe; returns at the negedge of hold cycle 1
  task automatic strobe(input logic [15:0] v);
    @(negedge clk); pause_valid = 1'b1; pause_time = v;
    @(negedge clk); pause_valid = 1'b0;
  endtask

  task automatic settle;
    strobe(16'h0000); wait_n(2);
  endtask

  task automatic t_reset;
    wait_n(2); chk(1'b1, "R1 reset");
  endtask

  task automatic t_basic(input logic [15:0] n);
    strobe(n); chk(1'b0, "R2 start");
    wait_n(n * P - 1); chk(1'b0, "R2 last held cycle");
    wait_n(1); chk(1'b1, "R2 release");
  endtask

  task automatic t_zero_idle;
    strobe(16'h0000); chk(1'b1, "R9 zero idle");
    wait_n(3); chk(1'b1, "R9 zero idle later");
  endtask

  task automatic t_release;
    strobe(16'd5); wait_n(100); chk(1'b0, "R3 held before");
    strobe(16'h0000); chk(1'b1, "R3 zero release");
  endtask

  task automatic t_reload;
    strobe(16'd1); wait_n(100);
    strobe(16'd3); chk(1'b0, "R4 reload start");
    wait_n(3 * P - 1); chk(1'b0, "R4 reload last held");
    wait_n(1); chk(1'b1, "R4 reload release");
  endtask

  task automatic t_defer;
    @(negedge clk); tx_busy = 1'b1;
    strobe(16'd1); wait_n(10); chk(1'b1, "R5 no hold mid-frame");
    tx_busy = 1'b0;
    wait_n(1); chk(1'b0, "R5 hold after frame");
    wait_n(P - 1); chk(1'b0, "R5 last held");
    wait_n(1); chk(1'b1, "R5 release");
  endtask

  task automatic t_replace;
    @(negedge clk); tx_busy = 1'b1;
    strobe(16'd4); wait_n(3);
    strobe(16'd1); wait_n(3);
    tx_busy = 1'b0;
    wait_n(1); chk(1'b0, "R6 hold start");
    wait_n(P - 1); chk(1'b0, "R6 last held");
    wait_n(1); chk(1'b1, "R6 second value used");
  endtask

  task automatic t_ctrl;
    strobe(16'd1); wait_n(10);
    next_is_ctrl = 1'b1; chk(1'b1, "R7 control passes");
    wait_n(50); chk(1'b1, "R7 control passes later");
    next_is_ctrl = 1'b0; chk(1'b0, "R7 data still held");
    wait_n(P - 61); chk(1'b0, "R7 last held");
    wait_n(1); chk(1'b1, "R7 original end");
  endtask

  task automatic t_disable;
    strobe(16'd3); wait_n(10); chk(1'b0, "R8 held before");
    fc_enable = 1'b0; chk(1'b1, "R8 disabled open");
    strobe(16'd2); chk(1'b1, "R8 strobe ignored");
    wait_n(2); fc_enable = 1'b1; chk(1'b1, "R8 count cleared");
    wait_n(5); chk(1'b1, "R8 still open");
  endtask

  task automatic t_max;
    strobe(16'hFFFF); wait_n(1000); chk(1'b0, "R2 max quantity held");
    strobe(16'h0000); chk(1'b1, "R3 max released");
  endtask

  initial begin
    wait_n(3); rst_n = 1'b1;
    t_reset;
    t_basic(16'd1);
    t_basic(16'd2);
    t_zero_idle;
    t_release;
    t_reload;
    settle;
    t_defer;
    t_replace;
    t_ctrl;
    t_disable;
    t_max;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule